// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps an 8-bit status byte that tells software why the system last came out of reset. The reset sequencer reports each reset with a one-cycle pulse on one of four inputs: power-on, external pin, software, or any other source such as a watchdog. A fifth cause, the hard fault, is detected inside the block. The block watches the CPU fetch address and flags a fetch beyond the end of flash. Each cause applies its own retention pattern to the flag byte. Some bits are forced to one, some are cleared and some are kept. A flag therefore survives the resets that do not concern it.

After every reset event the byte is locked against software writes for a fixed number of cycles. Once that window ends, software may read the byte and clear flags by writing zeros. When the CPU is in debug mode and the debug reset enable is low, a hard fault does not request a reset. It only raises the hard-fault flag.

Top module: `rcf_flag_reg`

## Requirements
- R1: After reset (rst_n low) and one cycle after a power-on pulse, rd_data is 8'h00.
- R2: One cycle after a software reset pulse, bit 7 is 1, bit 6 keeps its previous value, and bits 5..0 are 0.
- R3: One cycle after a pin reset pulse, bit 6 is 1, bit 7 keeps its previous value, and bits 5..0 are 0.
- R4: One cycle after an other-source reset pulse, bits 7..5 keep their previous values and bits 4..0 are 0.
- R5: A hard fault occurs when fetch_valid is 1, fetch_addr >= FLASH_BYTES and fault_irq_en is 0, unless debug suppression (R6) applies. One cycle later hf_reset_req is 1 for exactly one cycle. In that same cycle, bits 7 and 6 are kept, bit 5 is 1 and bits 4..0 are 0.
- R6: When dbg_mode is 1 and dbg_reset_en is 0, a hard fault does not raise hf_reset_req and does not lock writes. It sets bit 5 one cycle later and leaves the other bits unchanged. If a reset pulse arrives in the same cycle, the reset pattern applies instead.
- R7: A fetch below FLASH_BYTES, a fetch made while fault_irq_en is 1, or a cycle with fetch_valid at 0 has no effect on rd_data or hf_reset_req.
- R8: When several causes arrive in the same cycle, only one pattern is applied. The order of precedence is power-on, then pin, then software, then hard fault, then other.
- R9: Bit 1 always reads 0, including after a write of 1 to it.
- R10: While sw_ready is 1 and no reset event occurs, wr_en loads wr_data into the byte one cycle later, with bit 1 forced to 0.
- R11: A reset event (any pulse or an R5 hard fault) reloads the release timer. sw_ready is then 0 for RELEASE_CYCLES cycles. Writes made in the cycle of the event or while sw_ready is 0 are ignored.
- R12: If a write is accepted in the same cycle as an R6 flag-only set, bit 5 ends at 1 and the other bits take wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the block |
| por_evt | input | 1 | Power-on reset pulse |
| pin_evt | input | 1 | External pin reset pulse |
| soft_evt | input | 1 | Software reset pulse |
| other_evt | input | 1 | Reset pulse from any other source |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | AW | CPU fetch address |
| fault_irq_en | input | 1 | 1 routes an out-of-range fetch to an interrupt, so no flag is set and no reset occurs |
| dbg_mode | input | 1 | CPU is in debug mode |
| dbg_reset_en | input | 1 | Allows hard-fault reset while in debug mode |
| hf_reset_req | output | 1 | One-cycle hard-fault reset request |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| rd_data | output | 8 | Flag byte: bit 7 software, bit 6 pin, bit 5 hard fault, bit 1 always 0 |
| sw_ready | output | 1 | Register released for software writes |

## Verification
Every result is registered once. The new flag byte, the level of sw_ready and the hf_reset_req pulse are all due one clock edge after the input cycle that causes them. The bench drives each input cycle at the falling edge and updates its own model with that cycle's inputs. It then compares all three outputs 1 ns after the next rising edge. The lock window is followed cycle by cycle in the model, so writes that land inside the window or exactly on its last cycle are judged at that same one-edge latency.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  localparam int FLAG_W    = 8;
  localparam int SOFT_BIT  = 7;
  localparam int PIN_BIT   = 6;
  localparam int FAULT_BIT = 5;
  localparam int ZERO_BIT  = 1;
  localparam int N_CAUSE   = 5;

  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_POWER = 3'd1,
    RC_PIN   = 3'd2,
    RC_SOFT  = 3'd3,
    RC_FAULT = 3'd4,
    RC_OTHER = 3'd5
  } rcause_e;

  // request index order equals precedence: 0 is served first
  function automatic rcause_e idx_to_cause(input int idx);
    case (idx)
      0:       return RC_POWER;
      1:       return RC_PIN;
      2:       return RC_SOFT;
      3:       return RC_FAULT;
      4:       return RC_OTHER;
      default: return RC_NONE;
    endcase
  endfunction

  // retention pattern applied by each reset cause
  function automatic logic [FLAG_W-1:0] reset_pattern(input logic [FLAG_W-1:0] cur,
                                                      input rcause_e c);
    logic [FLAG_W-1:0] r;
    r = '0;
    case (c)
      RC_POWER: r = '0;
      RC_PIN: begin
        r[SOFT_BIT] = cur[SOFT_BIT];
        r[PIN_BIT]  = 1'b1;
      end
      RC_SOFT: begin
        r[SOFT_BIT] = 1'b1;
        r[PIN_BIT]  = cur[PIN_BIT];
      end
      RC_FAULT: begin
        r[SOFT_BIT]  = cur[SOFT_BIT];
        r[PIN_BIT]   = cur[PIN_BIT];
        r[FAULT_BIT] = 1'b1;
      end
      RC_OTHER: begin
        r[SOFT_BIT]  = cur[SOFT_BIT];
        r[PIN_BIT]   = cur[PIN_BIT];
        r[FAULT_BIT] = cur[FAULT_BIT];
      end
      default: r = cur;
    endcase
    return r;
  endfunction

  // software write view: the read-only bit never stores a one
  function automatic logic [FLAG_W-1:0] sw_write(input logic [FLAG_W-1:0] d);
    logic [FLAG_W-1:0] r;
    r = d;
    r[ZERO_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/rcf_fault_detect.sv
module rcf_fault_detect #(
  parameter int AW          = 16,
  parameter int FLASH_BYTES = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fault_irq_en,
  input  logic          dbg_mode,
  input  logic          dbg_reset_en,
  output logic          fault_reset,
  output logic          fault_flag_only,
  output logic          hf_reset_req
);

  localparam logic [AW:0] LIMIT = (AW+1)'(FLASH_BYTES);

  logic beyond_flash;
  logic fault_seen;
  logic dbg_suppress;

  assign beyond_flash    = fetch_valid && ({1'b0, fetch_addr} >= LIMIT);
  assign fault_seen      = beyond_flash && !fault_irq_en;
  assign dbg_suppress    = dbg_mode && !dbg_reset_en;
  assign fault_reset     = fault_seen && !dbg_suppress;
  assign fault_flag_only = fault_seen && dbg_suppress;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hf_reset_req <= 1'b0;
    else        hf_reset_req <= fault_reset;
  end

  // R5: a detected fault requests a reset on the next cycle
  a_r5_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fault_reset |=> hf_reset_req);
  // R6: a debug-suppressed fault never requests a reset
  a_r6_dbg_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag_only |=> !hf_reset_req);
  // R7: no fetch, no request
  a_r7_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !hf_reset_req);

endmodule

// File: rtl/rcf_cause_arb.sv
module rcf_cause_arb
  import rcf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] req_vec,
  output logic [N_CAUSE-1:0] gnt_vec,
  output logic               any_evt,
  output rcause_e            cause
);

  logic taken;

  always_comb begin
    taken = 1'b0;
    for (int i = 0; i < N_CAUSE; i++) begin
      gnt_vec[i] = req_vec[i] && !taken;
      taken      = taken | req_vec[i];
    end
  end

  assign any_evt = |req_vec;

  always_comb begin
    cause = RC_NONE;
    for (int i = N_CAUSE - 1; i >= 0; i--) begin
      if (gnt_vec[i]) cause = idx_to_cause(i);
    end
  end

  // R8: a single winner at a time
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));
  // R8: power-on beats every other cause
  a_r8_power_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[0] |-> cause == RC_POWER);
  // R8: pin beats software, fault and other
  a_r8_pin_over_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec[1] && !req_vec[0]) |-> cause == RC_PIN);

endmodule

// File: rtl/rcf_release_timer.sv
module rcf_release_timer #(
  parameter int RELEASE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);

  localparam int CW = (RELEASE_CYCLES < 2) ? 1 : $clog2(RELEASE_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(RELEASE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  // R11: a reset event reloads the lock window
  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == RELOAD);
  // R11: the window only counts down while no event arrives
  a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !ready) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rcf_flag_reg.sv
module rcf_flag_reg
  import rcf_pkg::*;
#(
  parameter int AW             = 16,
  parameter int FLASH_BYTES    = 32768,
  parameter int RELEASE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_evt,
  input  logic          pin_evt,
  input  logic          soft_evt,
  input  logic          other_evt,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fault_irq_en,
  input  logic          dbg_mode,
  input  logic          dbg_reset_en,
  output logic          hf_reset_req,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          sw_ready
);

  logic               fault_reset;
  logic               fault_flag_only;
  logic [N_CAUSE-1:0] req_vec;
  logic [N_CAUSE-1:0] gnt_vec;
  logic               any_evt;
  rcause_e            cause;
  logic               wr_accept;
  logic [FLAG_W-1:0]  flags_q;
  logic [FLAG_W-1:0]  flags_d;

  rcf_fault_detect #(
    .AW          (AW),
    .FLASH_BYTES (FLASH_BYTES)
  ) u_detect (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid     (fetch_valid),
    .fetch_addr      (fetch_addr),
    .fault_irq_en    (fault_irq_en),
    .dbg_mode        (dbg_mode),
    .dbg_reset_en    (dbg_reset_en),
    .fault_reset     (fault_reset),
    .fault_flag_only (fault_flag_only),
    .hf_reset_req    (hf_reset_req)
  );

  // precedence order: power-on, pin, software, fault, other
  assign req_vec = {other_evt, fault_reset, soft_evt, pin_evt, por_evt};

  rcf_cause_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (req_vec),
    .gnt_vec (gnt_vec),
    .any_evt (any_evt),
    .cause   (cause)
  );

  rcf_release_timer #(
    .RELEASE_CYCLES (RELEASE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (any_evt),
    .ready (sw_ready)
  );

  assign wr_accept = wr_en && sw_ready && !any_evt;

  always_comb begin
    flags_d = flags_q;
    if (any_evt) begin
      flags_d = reset_pattern(flags_q, cause);
    end else begin
      if (wr_accept)       flags_d = sw_write(wr_data);
      if (fault_flag_only) flags_d[FAULT_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign rd_data = flags_q;

  // R1: power-on clears everything
  a_r1_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> rd_data == 8'h00);
  // R2: software reset pattern
  a_r2_soft_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_SOFT) |=> (rd_data[7] && rd_data[5:0] == 6'd0
                            && rd_data[6] == $past(rd_data[6])));
  // R3: pin reset pattern
  a_r3_pin_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_PIN) |=> (rd_data[6] && rd_data[5:0] == 6'd0
                           && rd_data[7] == $past(rd_data[7])));
  // R4: other reset keeps the upper three flags
  a_r4_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_OTHER) |=> (rd_data[7:5] == $past(rd_data[7:5])
                             && rd_data[4:0] == 5'd0));
  // R5: hard-fault reset sets its flag
  a_r5_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_FAULT) |=> (rd_data[5] && rd_data[7:6] == $past(rd_data[7:6])));
  // R9: read-only bit
  a_r9_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ZERO_BIT] == 1'b0);
  // R11: locked writes leave the byte alone
  a_r11_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_ready && !any_evt && !fault_flag_only) |=> $stable(rd_data));
  // R12: hardware set beats a concurrent write
  a_r12_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag_only && !any_evt) |=> rd_data[FAULT_BIT]);

endmodule

// File: tb/rcf_flag_reg_tb_top.sv
module rcf_flag_reg_tb_top;

  localparam int AW    = 16;
  localparam int FLASH = 32768;
  localparam int REL   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          por_evt = 0, pin_evt = 0, soft_evt = 0, other_evt = 0;
  logic          fetch_valid = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fault_irq_en = 0, dbg_mode = 0, dbg_reset_en = 0;
  logic          hf_reset_req;
  logic          wr_en = 0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          sw_ready;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [7:0] m_flags = 8'h00;
  int         m_lock  = 0;
  logic       m_req   = 1'b0;

  always #2 clk = ~clk;

  rcf_flag_reg #(.AW(AW), .FLASH_BYTES(FLASH), .RELEASE_CYCLES(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pin_evt(pin_evt),
    .soft_evt(soft_evt), .other_evt(other_evt), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fault_irq_en(fault_irq_en), .dbg_mode(dbg_mode),
    .dbg_reset_en(dbg_reset_en), .hf_reset_req(hf_reset_req), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sw_ready(sw_ready)
  );

  function automatic logic [7:0] model_flags(logic [7:0] cur, bit por, bit pin,
      bit sw, bit fire, bit oth, bit only, bit wr_ok, logic [7:0] wd);
    logic [7:0] n;
    if (por)       n = 8'h00;
    else if (pin)  n = {cur[7], 1'b1, 6'b000000};
    else if (sw)   n = {1'b1, cur[6], 6'b000000};
    else if (fire) n = {cur[7:6], 1'b1, 5'b00000};
    else if (oth)  n = {cur[7:5], 5'b00000};
    else begin
      n = wr_ok ? (wd & 8'hFD) : cur;
      if (only) n = n | 8'h20;
    end
    return n;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit por, bit pin, bit sw, bit oth, bit fv, logic [AW-1:0] fa,
                      bit irq, bit dbg, bit dre, bit we, logic [7:0] wd, string tag);
    bit fault, fire, only, evt, wr_ok;
    string t;
    @(negedge clk);
    por_evt = por; pin_evt = pin; soft_evt = sw; other_evt = oth;
    fetch_valid = fv; fetch_addr = fa; fault_irq_en = irq;
    dbg_mode = dbg; dbg_reset_en = dre; wr_en = we; wr_data = wd;
    fault = fv && (int'(fa) >= FLASH) && !irq;
    fire  = fault && (!dbg || dre);
    only  = fault && !fire;
    evt   = por || pin || sw || oth || fire;
    wr_ok = we && (m_lock == 0) && !evt;
    m_flags = model_flags(m_flags, por, pin, sw, fire, oth, only && !evt, wr_ok, wd);
    m_req   = fire;
    if (evt) m_lock = REL;
    else if (m_lock > 0) m_lock--;
    t = tag;
    if (t == "") begin
      if ((int'(por) + int'(pin) + int'(sw) + int'(oth) + int'(fire)) > 1) t = "R8";
      else if (por)  t = "R1";
      else if (pin)  t = "R3";
      else if (sw)   t = "R2";
      else if (fire) t = "R5";
      else if (oth)  t = "R4";
      else if (only) t = "R6";
      else if (we && !wr_ok) t = "R11";
      else if (we)   t = "R10";
      else           t = "R7";
    end
    @(posedge clk);
    #1;
    check(t, "rd_data", rd_data, m_flags);
    check(t, "sw_ready", {7'd0, sw_ready}, {7'd0, (m_lock == 0)});
    check(t, "hf_reset_req", {7'd0, hf_reset_req}, {7'd0, m_req});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0,0,0,0, 0,'0, 0,0,0, 0,8'h00, "R11");
  endtask

  initial begin : watchdog
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rd_data after rst", rd_data, 8'h00);
    check("R1", "sw_ready after rst", {7'd0, sw_ready}, 8'h01);
    rst_n = 1'b1;

    // R10 R9: write all ones, bit 1 must stay low
    step(0,0,0,0, 0,'0, 0,0,0, 1,8'hFF, "R9");
    step(0,0,0,0, 0,'0, 0,0,0, 1,8'h1C, "R10");
    // R3 pin reset, then R11 write during lock
    step(0,1,0,0, 0,'0, 0,0,0, 1,8'h00, "R3");
    step(0,0,0,0, 0,'0, 0,0,0, 1,8'h00, "R11");
    idle(REL);
    // R2 software reset keeps pin flag
    step(0,0,1,0, 0,'0, 0,0,0, 0,8'h00, "R2");
    idle(REL);
    // R7 boundaries: last flash address, then irq enabled
    step(0,0,0,0, 1,16'(FLASH-1), 0,0,0, 0,8'h00, "R7");
    step(0,0,0,0, 1,16'(FLASH), 1,0,0, 0,8'h00, "R7");
    // R5 first address beyond flash
    step(0,0,0,0, 1,16'(FLASH), 0,0,0, 0,8'h00, "R5");
    idle(REL);
    // R4 other reset keeps upper flags
    step(0,0,0,1, 0,'0, 0,0,0, 0,8'h00, "R4");
    idle(REL);
    // R6 R12 debug flag-only set against a clearing write
    step(0,0,0,0, 1,16'hFFFF, 0,1,0, 1,8'h00, "R12");
    step(0,0,0,0, 1,16'hFFFF, 0,1,0, 0,8'h00, "R6");
    // R8 collisions
    step(0,1,1,1, 1,16'hFFFF, 0,0,1, 0,8'h00, "R8");
    idle(REL);
    step(0,0,1,1, 1,16'hFFFF, 0,0,1, 0,8'h00, "R8");
    step(1,1,1,1, 1,16'hFFFF, 0,0,1, 1,8'hFF, "R8");
    idle(REL);
    step(1,0,0,0, 0,'0, 0,0,0, 0,8'h00, "R1");

    for (int k = 0; k < 3000; k++) begin
      bit por, pin, sw, oth, fv, irq, dbg, dre, we;
      por = ($urandom % 40) == 0;
      pin = ($urandom % 10) == 0;
      sw  = ($urandom % 10) == 0;
      oth = ($urandom % 10) == 0;
      fv  = ($urandom % 3) == 0;
      irq = ($urandom % 3) == 0;
      dbg = ($urandom % 2) == 0;
      dre = ($urandom % 2) == 0;
      we  = ($urandom % 3) == 0;
      step(por, pin, sw, oth, fv, 16'($urandom), irq, dbg, dre, we, 8'($urandom), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule